// File: doc/BRIEF.md
# Serial Gold-Sequence Scrambler and QPSK Symbol Mapper

This block takes a broadcast-channel bitstream arriving one bit per clock under a valid strobe, whitens every bit by XOR with one bit of a pseudo-random Gold sequence, and packs each pair of whitened bits into one complex QPSK symbol. The Gold sequence is the XOR of two 31-stage LFSR sequences. The first generator always starts from the same fixed seed. The second starts from a per-channel seed taken from the `seed_i` input when `load_i` is pulsed.

After a load, both generators run freely for a fixed warm-up count before any data bit is accepted. `ready_o` shows when the warm-up is over. From then on, each accepted bit advances the sequence by one position. The first whitened bit of a pair is held in a one-bit buffer. The second bit completes the pair, and a 16-bit symbol `{I, Q}` appears on `sym_o` together with a one-cycle `sym_vld_o` pulse.

Control is a four-state machine. `ST_IDLE` is the state after reset, and no bit is accepted there. `ST_WARM` advances both generators on every cycle and moves to `ST_EVEN` once the warm-up count is complete. `ST_EVEN` waits for the first bit of a pair and moves to `ST_ODD` when it arrives. `ST_ODD` waits for the second bit, emits the symbol, and returns to `ST_EVEN`. A load in any state goes to `ST_WARM`. A load therefore restarts the warm-up and drops any buffered bit.

Top module: `gold_qpsk_scrambler`

## Requirements
- R1: While `rst_n` is low and after it is released, `ready_o` and `sym_vld_o` are 0 and `sym_o` is 16'h0000. No bit is accepted and no symbol is produced until the first load.
- R2: On a cycle with `load_i` high, the fixed generator is seeded with 1 in its lowest stage and 0 in the other stages, and the channel generator is seeded with `seed_i`. Load takes priority over `bit_vld_i`, and any first bit that is being held is discarded.
- R3: The fixed generator follows a(n+31) = a(n+3) XOR a(n). The channel generator follows b(n+31) = b(n+3) XOR b(n+2) XOR b(n+1) XOR b(n). Stage k of the seed holds element k of the sequence. With an all-zero channel seed, the Gold sequence equals the fixed sequence alone.
- R4: `ready_o` rises exactly WARMUP (1600 by default) cycles after the load edge. Bits offered before that are ignored and do not move the sequence. A further load during warm-up restarts the count.
- R5: The k-th accepted bit after a load is XORed with a(1600+k) XOR b(1600+k). The sequence advances only on accepted bits.
- R6: `sym_vld_o` is high for exactly one cycle, in the cycle after every second accepted bit. It is never high on two consecutive cycles.
- R7: I is `sym_o[15:8]` and is taken from the first whitened bit of the pair. Q is `sym_o[7:0]` and is taken from the second. A 0 gives +90 (8'h5A) and a 1 gives -90 (8'hA6).
- R8: `sym_o` keeps its last value in every cycle where `sym_vld_o` is low.
- R9: Cycles without `bit_vld_i` between accepted bits leave the pairing and the sequence position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Reseed both generators and restart the warm-up |
| seed_i | input | 31 | Per-channel seed for the channel generator |
| bit_vld_i | input | 1 | `bit_i` carries a data bit this cycle |
| bit_i | input | 1 | Serial data bit |
| ready_o | output | 1 | Warm-up complete; data bits are accepted |
| sym_vld_o | output | 1 | One-cycle strobe for a new symbol on `sym_o` |
| sym_o | output | 16 | Symbol: I in bits 15:8, Q in bits 7:0, two's complement |

## Verification
The hardest case to reach from the ports is a load that arrives while a first bit is held in the pair buffer. A close second is a load during warm-up, because the count must restart instead of finishing. The stimulus counts accepted bits since ready so that it can assert `load_i` on an odd count. It also issues a second load partway through a warm-up. The reference model then checks that the next symbol pairs two fresh bits at the sequence start of the new seed. An all-zero channel seed isolates the fixed generator, and a stream of zero data bits exposes the raw Gold sequence on the symbol signs.

// File: rtl/gqs_pkg.sv
package gqs_pkg;

    localparam int LFSR_LEN = 31;

    // Feedback masks: bit k set means stage k enters the XOR feedback
    localparam logic [LFSR_LEN-1:0] FIXED_TAPS   = 31'h0000_0009;
    localparam logic [LFSR_LEN-1:0] CHANNEL_TAPS = 31'h0000_000F;
    localparam logic [LFSR_LEN-1:0] FIXED_SEED   = 31'h0000_0001;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WARM,
        ST_EVEN,
        ST_ODD
    } gqs_state_e;

endpackage

// File: rtl/gqs_lfsr.sv
module gqs_lfsr #(
    parameter int          LEN     = 31,
    parameter logic [30:0] TAPS    = 31'h9,
    parameter logic [30:0] RST_VAL = 31'h1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [LEN-1:0] seed_i,
    input  logic           adv_i,
    output logic           bit_o
);

    logic [LEN-1:0] stages_q;
    logic           fb;

    // stage k holds sequence element n+k; the new element enters at the top
    assign fb    = ^(stages_q & TAPS[LEN-1:0]);
    assign bit_o = stages_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages_q <= RST_VAL[LEN-1:0];
        end else if (load_i) begin
            stages_q <= seed_i;
        end else if (adv_i) begin
            stages_q <= {fb, stages_q[LEN-1:1]};
        end
    end

endmodule

// File: rtl/gqs_ctrl.sv
module gqs_ctrl
    import gqs_pkg::*;
#(
    parameter int WARMUP = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic bit_vld_i,
    output logic adv_o,
    output logic ready_o,
    output logic hold_we_o,
    output logic emit_o
);

    localparam int CNT_W = $clog2(WARMUP + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WARMUP - 1);

    gqs_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // warm-up counter
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            cnt_q <= '0;
        end else if (state_q == ST_WARM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = ST_WARM;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_WARM: if (cnt_q == CNT_LAST) state_d = ST_EVEN;
                ST_EVEN: if (bit_vld_i) state_d = ST_ODD;
                ST_ODD:  if (bit_vld_i) state_d = ST_EVEN;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        adv_o     = 1'b0;
        ready_o   = 1'b0;
        hold_we_o = 1'b0;
        emit_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WARM: adv_o = !load_i;
            ST_EVEN: begin
                ready_o   = 1'b1;
                adv_o     = bit_vld_i && !load_i;
                hold_we_o = bit_vld_i && !load_i;
            end
            ST_ODD: begin
                ready_o = 1'b1;
                adv_o   = bit_vld_i && !load_i;
                emit_o  = bit_vld_i && !load_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/gqs_mapper.sv
module gqs_mapper #(
    parameter int SYM_W = 16,
    parameter int AMP   = 90
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_we_i,
    input  logic             emit_i,
    input  logic             sc_bit_i,
    output logic             sym_vld_o,
    output logic [SYM_W-1:0] sym_o
);

    localparam int COMP_W = SYM_W / 2;
    localparam logic [COMP_W-1:0] LVL_POS = COMP_W'(AMP);
    localparam logic [COMP_W-1:0] LVL_NEG = COMP_W'(-AMP);

    logic             held_q;
    logic [1:0]       pair;
    logic [SYM_W-1:0] sym_d;

    // pair[1] = first bit (I), pair[0] = second bit (Q)
    assign pair = {held_q, sc_bit_i};

    for (genvar g = 0; g < 2; g++) begin : g_comp
        assign sym_d[g*COMP_W +: COMP_W] = pair[g] ? LVL_NEG : LVL_POS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (hold_we_i) begin
            held_q <= sc_bit_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_vld_o <= 1'b0;
            sym_o     <= '0;
        end else begin
            sym_vld_o <= emit_i;
            if (emit_i) begin
                sym_o <= sym_d;
            end
        end
    end

endmodule

// File: rtl/gold_qpsk_scrambler.sv
module gold_qpsk_scrambler
    import gqs_pkg::*;
#(
    parameter int WARMUP = 1600,
    parameter int SYM_W  = 16,
    parameter int AMP    = 90
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [LFSR_LEN-1:0] seed_i,
    input  logic                bit_vld_i,
    input  logic                bit_i,
    output logic                ready_o,
    output logic                sym_vld_o,
    output logic [SYM_W-1:0]    sym_o
);

    logic adv;
    logic hold_we;
    logic emit;
    logic fixed_bit;
    logic chan_bit;
    logic sc_bit;

    gqs_ctrl #(.WARMUP(WARMUP)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .bit_vld_i (bit_vld_i),
        .adv_o     (adv),
        .ready_o   (ready_o),
        .hold_we_o (hold_we),
        .emit_o    (emit)
    );

    gqs_lfsr #(
        .LEN     (LFSR_LEN),
        .TAPS    (FIXED_TAPS),
        .RST_VAL (FIXED_SEED)
    ) u_fixed (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .seed_i (FIXED_SEED),
        .adv_i  (adv),
        .bit_o  (fixed_bit)
    );

    gqs_lfsr #(
        .LEN     (LFSR_LEN),
        .TAPS    (CHANNEL_TAPS),
        .RST_VAL ('0)
    ) u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .seed_i (seed_i),
        .adv_i  (adv),
        .bit_o  (chan_bit)
    );

    assign sc_bit = bit_i ^ fixed_bit ^ chan_bit;

    gqs_mapper #(.SYM_W(SYM_W), .AMP(AMP)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_we_i (hold_we),
        .emit_i    (emit),
        .sc_bit_i  (sc_bit),
        .sym_vld_o (sym_vld_o),
        .sym_o     (sym_o)
    );

endmodule

// File: rtl/gqs_checker.sv
module gqs_checker #(
    parameter int SYM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic             bit_vld_i,
    input logic             ready_o,
    input logic             sym_vld_o,
    input logic [SYM_W-1:0] sym_o
);

    localparam int COMP_W = SYM_W / 2;

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!ready_o && !sym_vld_o));

    p_load_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!ready_o && !sym_vld_o));

    p_ready_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !load_i) |=> ready_o);

    p_sym_after_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld_o && !$past(!rst_n)) |-> ($past(ready_o) && $past(bit_vld_i) && !$past(load_i)));

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld_o |=> !sym_vld_o);

    p_levels_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld_o |-> ((sym_o[SYM_W-1 -: COMP_W] == 8'h5A || sym_o[SYM_W-1 -: COMP_W] == 8'hA6) &&
                       (sym_o[COMP_W-1:0] == 8'h5A || sym_o[COMP_W-1:0] == 8'hA6)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_vld_o && !$past(!rst_n)) |-> $stable(sym_o));

endmodule

bind gold_qpsk_scrambler gqs_checker #(.SYM_W(SYM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .bit_vld_i (bit_vld_i),
    .ready_o   (ready_o),
    .sym_vld_o (sym_vld_o),
    .sym_o     (sym_o)
);

// File: tb/gold_qpsk_scrambler_bench.sv
module gold_qpsk_scrambler_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WARM       = 1600;
    localparam int NB         = 400;
    localparam int SEQ        = WARM + NB + 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [30:0] seed_i = '0;
    logic        bit_vld_i = 1'b0;
    logic        bit_i = 1'b0;
    logic        ready_o;
    logic        sym_vld_o;
    logic [15:0] sym_o;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    bit        gold [0:NB-1];
    bit        m_ready;
    int        m_wait;
    int        m_k;
    bit        m_have;
    bit        m_first;
    bit        e_vld;
    bit [15:0] e_sym;
    int        acc_since_ready;

    always #(CLK_PERIOD/2) clk = ~clk;

    gold_qpsk_scrambler u_gold_qpsk_scrambler (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .seed_i    (seed_i),
        .bit_vld_i (bit_vld_i),
        .bit_i     (bit_i),
        .ready_o   (ready_o),
        .sym_vld_o (sym_vld_o),
        .sym_o     (sym_o)
    );

    function automatic bit [7:0] lvl(input bit b);
        return b ? 8'hA6 : 8'h5A;
    endfunction

    task automatic build_gold(input logic [30:0] s);
        bit a [0:SEQ-1];
        bit c [0:SEQ-1];
        for (int n = 0; n < SEQ; n++) begin
            a[n] = 1'b0;
            c[n] = 1'b0;
        end
        a[0] = 1'b1;
        for (int n = 0; n < 31; n++) c[n] = s[n];
        for (int n = 0; n + 31 < SEQ; n++) begin
            a[n+31] = a[n+3] ^ a[n];
            c[n+31] = c[n+3] ^ c[n+2] ^ c[n+1] ^ c[n];
        end
        for (int k = 0; k < NB; k++) gold[k] = a[WARM+k] ^ c[WARM+k];
    endtask

    task automatic model_reset();
        m_ready = 1'b0; m_wait = 0; m_k = 0; m_have = 1'b0; m_first = 1'b0;
        e_vld = 1'b0; e_sym = 16'h0000; acc_since_ready = 0;
    endtask

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic tick(input string tag, input bit rst, input bit ld, input logic [30:0] sd,
                        input bit v, input bit b);
        bit sc;
        rst_n = !rst; load_i = ld; seed_i = sd; bit_vld_i = v; bit_i = b;
        @(posedge clk);
        e_vld = 1'b0;
        if (rst) begin
            model_reset();
        end else if (ld) begin
            build_gold(sd);
            m_wait = WARM; m_ready = 1'b0; m_k = 0; m_have = 1'b0; acc_since_ready = 0;
        end else if (!m_ready) begin
            if (m_wait > 0) begin
                m_wait--;
                if (m_wait == 0) m_ready = 1'b1;
            end
        end else if (v) begin
            sc = b ^ gold[m_k];
            m_k++;
            acc_since_ready++;
            if (!m_have) begin
                m_first = sc; m_have = 1'b1;
            end else begin
                e_vld = 1'b1; e_sym = {lvl(m_first), lvl(sc)}; m_have = 1'b0;
            end
        end
        @(negedge clk);
        check(tag, "ready_o", {15'd0, ready_o}, {15'd0, m_ready});
        check(tag, "sym_vld_o", {15'd0, sym_vld_o}, {15'd0, e_vld});
        check(tag, "sym_o", sym_o, e_sym);
    endtask

    task automatic run_bits(input string tag, input int n, input int gap_pct, input int data_mode);
        for (int i = 0; i < n; i++) begin
            bit v;
            bit d;
            v = ($urandom_range(0, 99) >= gap_pct);
            d = (data_mode == 0) ? 1'b0 : (data_mode == 1) ? 1'b1 : 1'($urandom_range(0, 1));
            tick(tag, 1'b0, 1'b0, 31'h0, v, d);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        // R1: reset state and no activity before a load
        for (int i = 0; i < 4; i++) tick("R1", 1'b1, 1'b0, 31'h0, 1'b1, 1'b1);
        run_bits("R1", 20, 0, 2);

        // R2 load, then R4 warm-up with bits offered (ignored)
        tick("R2", 1'b0, 1'b1, 31'h1234_567, 1'b1, 1'b1);
        run_bits("R4", WARM, 0, 2);

        // R5: zero data exposes the Gold sequence
        run_bits("R5", 64, 0, 0);
        // R6: continuous random data
        run_bits("R6", 64, 0, 2);
        // R7: all-ones data
        run_bits("R7", 32, 0, 1);
        // R9: gappy valid strobe
        run_bits("R9", 120, 50, 2);
        // R8: long idle after a symbol, output must hold
        while (!e_vld) tick("R8", 1'b0, 1'b0, 31'h0, 1'b1, 1'($urandom_range(0, 1)));
        run_bits("R8", 30, 100, 2);

        // R2: load while a first bit is held, all-zero seed (R3)
        if (acc_since_ready % 2 == 0) tick("R2", 1'b0, 1'b0, 31'h0, 1'b1, 1'b1);
        tick("R2", 1'b0, 1'b1, 31'h0, 1'b1, 1'b0);
        run_bits("R3", WARM, 100, 2);
        run_bits("R3", 60, 0, 0);

        // R4: reload during warm-up restarts the count
        tick("R4", 1'b0, 1'b1, 31'h7FFF_FFFF, 1'b0, 1'b0);
        run_bits("R4", 500, 30, 2);
        tick("R4", 1'b0, 1'b1, 31'h2AAA_AAAA, 1'b0, 1'b0);
        run_bits("R4", WARM, 0, 2);
        run_bits("R5", 50, 20, 2);

        // R1: reset in mid-stream
        tick("R1", 1'b1, 1'b0, 31'h0, 1'b1, 1'b1);
        run_bits("R1", 10, 0, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule